// File: doc/BRIEF.md
# Indexed Peripheral Register Block with Interrupt Gate

This block is a bus slave for a peripheral that answers every access in the same cycle. A small local address decoder turns the device enable, the write strobe and a word offset into per-register write enables, and picks the read data from the addressed register. Behind the decoder sit a control word that the device logic reads, an index register, a bank of target registers that all share one data offset and are reached through the index, a trigger offset that emits a single-cycle start strobe without storing anything, and a two-bit interrupt register.

The interrupt register holds a pending flag and an enable flag. The device side sets the pending flag with a one-cycle event pulse. Software clears it by writing a 0 to it. The enable flag is changed only by bus writes. The interrupt line is the AND of the two flags and stays high for as long as both are set. Software reaches a banked register in two steps: it writes the register number to the index offset, then reads or writes the shared data offset.

Top module: `periph_regblk`

## Requirements
- R1: The wait output `stall_o` is low in every cycle, for reads, writes and idle cycles alike.
- R2: After reset, all registers read as zero, and `irq_o` and `trig_o` are low.
- R3: The control register at word offset 0 loads `wdata` on a clock edge only when `dev_en`, `wr` and offset 0 are all present in that cycle. It drives `ctrl_o` and reads back at offset 0.
- R4: When `dev_en` is high and `wr` is low, `rdata` shows the addressed register in the same cycle. `rdata` is zero when `dev_en` is low, at the trigger offset 4, and at the unused offsets 5 to 7.
- R5: The index register at offset 1 loads `wdata[IDX_W-1:0]` and reads back zero-extended.
- R6: Accesses to offset 2 read or write banked register number `index`. A write changes only that one register.
- R7: With an index of `BANK_N` (8) or more, reads at offset 2 return zero and writes at offset 2 change no banked register.
- R8: A write to offset 4 with `wdata[TRIG_BIT]` (bit 0) set makes `trig_o` high for exactly the one cycle after that clock edge. Writes with that bit clear, and reads at offset 4, produce no strobe.
- R9: At offset 3, bit 0 is the pending flag and bit 1 is the enable flag. A bus write loads both bits. A `dev_event` pulse sets pending.
- R10: `irq_o` is high exactly when pending and enable are both 1.
- R11: When a `dev_event` pulse and a bus write of 0 to pending fall in the same cycle, pending ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| dev_en | input | 1 | Device select from the system address decoder |
| wr | input | 1 | 1 = write, 0 = read |
| loc_addr | input | LOC_AW | Local word offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| stall_o | output | 1 | Wait response, always low |
| dev_event | input | 1 | Device-side event pulse that sets the pending flag |
| ctrl_o | output | DATA_W | Control register value, for use by the device logic |
| trig_o | output | 1 | One-cycle start strobe |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The bank is loaded with a distinct value per index and read back in full, so any index mix-up shows as a wrong word. After that, an out-of-range index is written through to confirm that no slot changes. Each register offset is also tried with the select low, with reads and with writes, which separates decoder faults from storage faults. The trigger offset is driven with the strobe bit set, with only a different bit set, and with a read, which separates a strobe taken from the data bit from one taken from the address alone. The interrupt flags are walked through event-only, enable-only, bus-clear and event-with-clear patterns, which separates the AND gating from the set/clear priority.

// File: rtl/periph_pkg.sv
package periph_pkg;
   localparam int OFF_CTRL  = 0;
   localparam int OFF_INDEX = 1;
   localparam int OFF_BANK  = 2;
   localparam int OFF_IRQ   = 3;
   localparam int OFF_TRIG  = 4;
   localparam int N_OFFS    = 5;

   localparam int IRQ_PEND_BIT = 0;
   localparam int IRQ_EN_BIT   = 1;

   typedef struct packed {
      logic pend;
      logic en;
   } irq_state_t;
endpackage

// File: rtl/preg_decode.sv
module preg_decode
   import periph_pkg::*;
#(
   parameter int LOC_AW = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dev_en,
   input  logic              wr,
   input  logic [LOC_AW-1:0] loc_addr,
   output logic [N_OFFS-1:0] wr_sel,
   output logic [N_OFFS-1:0] rd_sel
);
   localparam int SPAN = 1 << LOC_AW;

   if (SPAN < N_OFFS) begin : g_bad_span
      $error("preg_decode: LOC_AW too small for the register map");
   end

   for (genvar k = 0; k < N_OFFS; k++) begin : g_sel
      logic hit;
      assign hit       = dev_en && (loc_addr == LOC_AW'(k));
      assign wr_sel[k] = hit && wr;
      assign rd_sel[k] = hit && !wr;
   end

   AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_sel | rd_sel)) else $error("decoder selects more than one offset"); // R4
endmodule

// File: rtl/preg_bank.sv
module preg_bank #(
   parameter int DATA_W = 32,
   parameter int BANK_N = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  idx,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd
);
   localparam int FLAT_W = DATA_W * BANK_N;

   if (BANK_N > (1 << IDX_W)) begin : g_bad_idx
      $error("preg_bank: IDX_W cannot address BANK_N registers");
   end
   if (BANK_N < 1) begin : g_bad_n
      $error("preg_bank: BANK_N must be at least 1");
   end

   logic [DATA_W-1:0] slot_q [BANK_N];
   logic [FLAT_W-1:0] flat;
   logic              in_range;

   assign in_range = ({1'b0, idx} < (IDX_W+1)'(BANK_N));

   for (genvar i = 0; i < BANK_N; i++) begin : g_slot
      logic hit;
      assign hit = we && (idx == IDX_W'(i));
      always_ff @(posedge clk or posedge rst) begin
         if (rst)      slot_q[i] <= '0;
         else if (hit) slot_q[i] <= wdata;
      end
      assign flat[i*DATA_W +: DATA_W] = slot_q[i];
   end

   always_comb begin
      rd = '0;
      for (int i = 0; i < BANK_N; i++) begin
         if (idx == IDX_W'(i)) rd = slot_q[i];
      end
   end

   AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (we && !in_range) |=> $stable(flat)) else $error("out-of-range write changed bank"); // R7
   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      !in_range |-> (rd == '0)) else $error("out-of-range read not zero"); // R7
endmodule

// File: rtl/preg_irq.sv
module preg_irq
   import periph_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dev_event,
   output irq_state_t        st,
   output logic              irq
);
   if (DATA_W <= IRQ_EN_BIT) begin : g_bad_w
      $error("preg_irq: DATA_W too narrow for the interrupt register");
   end

   logic pend_q, en_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else if (dev_event) begin
         pend_q <= 1'b1;
      end else if (we) begin
         pend_q <= wdata[IRQ_PEND_BIT];
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     en_q <= 1'b0;
      else if (we) en_q <= wdata[IRQ_EN_BIT];
   end

   assign st.pend = pend_q;
   assign st.en   = en_q;
   assign irq     = pend_q & en_q;

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
      dev_event |=> pend_q) else $error("device event lost"); // R11
   AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q) |-> $past(dev_event || (we && wdata[IRQ_PEND_BIT]))) else $error("pending set without cause"); // R9
   AST_EN_BUS_ONLY: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(en_q)) else $error("enable changed without bus write"); // R9
endmodule

// File: rtl/periph_regblk.sv
module periph_regblk
   import periph_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int LOC_AW   = 3,
   parameter int BANK_N   = 8,
   parameter int IDX_W    = 4,
   parameter int TRIG_BIT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dev_en,
   input  logic              wr,
   input  logic [LOC_AW-1:0] loc_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              stall_o,
   input  logic              dev_event,
   output logic [DATA_W-1:0] ctrl_o,
   output logic              trig_o,
   output logic              irq_o
);
   if (TRIG_BIT >= DATA_W) begin : g_bad_trig
      $error("periph_regblk: TRIG_BIT outside data word");
   end
   if (IDX_W > DATA_W) begin : g_bad_idx
      $error("periph_regblk: IDX_W wider than data word");
   end

   logic [N_OFFS-1:0] wr_sel, rd_sel;
   logic [DATA_W-1:0] ctrl_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] bank_rd;
   logic              trig_q;
   irq_state_t        irq_st;
   logic              irq_w;

   preg_decode #(.LOC_AW(LOC_AW)) u_dec (
      .clk      (clk),
      .rst      (rst),
      .dev_en   (dev_en),
      .wr       (wr),
      .loc_addr (loc_addr),
      .wr_sel   (wr_sel),
      .rd_sel   (rd_sel)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst)                   ctrl_q <= '0;
      else if (wr_sel[OFF_CTRL]) ctrl_q <= wdata;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)                    idx_q <= '0;
      else if (wr_sel[OFF_INDEX]) idx_q <= wdata[IDX_W-1:0];
   end

   preg_bank #(.DATA_W(DATA_W), .BANK_N(BANK_N), .IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .idx   (idx_q),
      .we    (wr_sel[OFF_BANK]),
      .wdata (wdata),
      .rd    (bank_rd)
   );

   preg_irq #(.DATA_W(DATA_W)) u_irq (
      .clk       (clk),
      .rst       (rst),
      .we        (wr_sel[OFF_IRQ]),
      .wdata     (wdata),
      .dev_event (dev_event),
      .st        (irq_st),
      .irq       (irq_w)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) trig_q <= 1'b0;
      else     trig_q <= wr_sel[OFF_TRIG] && wdata[TRIG_BIT];
   end

   always_comb begin
      rdata = '0;
      if (rd_sel[OFF_CTRL])  rdata = ctrl_q;
      if (rd_sel[OFF_INDEX]) rdata[IDX_W-1:0] = idx_q;
      if (rd_sel[OFF_BANK])  rdata = bank_rd;
      if (rd_sel[OFF_IRQ]) begin
         rdata[IRQ_PEND_BIT] = irq_st.pend;
         rdata[IRQ_EN_BIT]   = irq_st.en;
      end
   end

   assign stall_o = 1'b0;
   assign ctrl_o  = ctrl_q;
   assign trig_o  = trig_q;
   assign irq_o   = irq_w;

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(dev_en && wr && loc_addr == LOC_AW'(OFF_CTRL)) |=> $stable(ctrl_o)) else $error("control changed without write"); // R3
   AST_TRIG_CAUSE: assert property (@(posedge clk) disable iff (rst)
      trig_o |-> $past(dev_en && wr && loc_addr == LOC_AW'(OFF_TRIG) && wdata[TRIG_BIT])) else $error("strobe without trigger write"); // R8
   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      !dev_en |-> (rdata == '0)) else $error("read data while deselected"); // R4
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> (irq_st.en && irq_st.pend)) else $error("interrupt without both flags"); // R10
endmodule

// File: tb/sim_periph_regblk.sv
module sim_periph_regblk;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          dev_en = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] loc_addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          stall_o;
   logic          dev_event = 1'b0;
   logic [DW-1:0] ctrl_o;
   logic          trig_o;
   logic          irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   periph_regblk u0 (
      .clk(clk), .rst(rst), .dev_en(dev_en), .wr(wr), .loc_addr(loc_addr),
      .wdata(wdata), .rdata(rdata), .stall_o(stall_o), .dev_event(dev_event),
      .ctrl_o(ctrl_o), .trig_o(trig_o), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input int a, input logic [DW-1:0] d);
      dev_en = 1; wr = 1; loc_addr = AW'(a); wdata = d;
      @(negedge clk);
      check("R1 stall during write", {31'b0, stall_o}, 0);
      dev_en = 0; wr = 0; wdata = '0;
   endtask

   task automatic bus_rd(input int a, output logic [DW-1:0] d);
      dev_en = 1; wr = 0; loc_addr = AW'(a);
      #1 d = rdata;
      check("R1 stall during read", {31'b0, stall_o}, 0);
      @(negedge clk);
      dev_en = 0;
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      for (int a = 0; a < 4; a++) begin
         bus_rd(a, v);
         check($sformatf("R2 reset value offset %0d", a), v, 0);
      end
      check("R2 irq after reset", {31'b0, irq_o}, 0);
      check("R2 trig after reset", {31'b0, trig_o}, 0);
   endtask

   task automatic t_ctrl;
      logic [DW-1:0] v;
      bus_wr(0, 32'hA5A5_1234);
      bus_rd(0, v);
      check("R3 control readback", v, 32'hA5A5_1234);
      check("R3 control port", ctrl_o, 32'hA5A5_1234);
      dev_en = 0; wr = 1; loc_addr = 0; wdata = 32'h0BAD_0BAD;
      @(negedge clk);
      wr = 0; wdata = '0;
      check("R3 deselected write ignored", ctrl_o, 32'hA5A5_1234);
      bus_wr(1, 32'h0);
      check("R3 other-offset write ignored", ctrl_o, 32'hA5A5_1234);
   endtask

   task automatic t_readmux;
      logic [DW-1:0] v;
      for (int a = 4; a < 8; a++) begin
         bus_rd(a, v);
         check($sformatf("R4 offset %0d reads zero", a), v, 0);
      end
      dev_en = 0; loc_addr = 0;
      #1 check("R4 deselected read zero", rdata, 0);
      @(negedge clk);
   endtask

   task automatic t_bank;
      logic [DW-1:0] v;
      for (int i = 0; i < 8; i++) begin
         bus_wr(1, i);
         bus_wr(2, 32'h1000 + i * 3);
      end
      for (int i = 7; i >= 0; i--) begin
         bus_wr(1, i);
         bus_rd(1, v);
         check("R5 index readback", v, i);
         bus_rd(2, v);
         check($sformatf("R6 bank %0d", i), v, 32'h1000 + i * 3);
      end
      bus_wr(1, 32'hFFFF_FFF3);
      bus_rd(1, v);
      check("R5 index truncated to width", v, 3);
      check("R6 control untouched by bank", ctrl_o, 32'hA5A5_1234);
   endtask

   task automatic t_oor;
      logic [DW-1:0] v;
      bus_wr(1, 9);
      bus_wr(2, 32'hDEAD_BEEF);
      bus_rd(2, v);
      check("R7 out-of-range read", v, 0);
      bus_wr(1, 8);
      bus_rd(2, v);
      check("R7 index 8 read", v, 0);
      for (int i = 0; i < 8; i++) begin
         bus_wr(1, i);
         bus_rd(2, v);
         check($sformatf("R7 bank %0d unchanged", i), v, 32'h1000 + i * 3);
      end
   endtask

   task automatic t_trig;
      logic [DW-1:0] v;
      bus_wr(4, 32'h1);
      check("R8 strobe high", {31'b0, trig_o}, 1);
      @(negedge clk);
      check("R8 strobe one cycle", {31'b0, trig_o}, 0);
      bus_wr(4, 32'h2);
      check("R8 no strobe without bit", {31'b0, trig_o}, 0);
      bus_rd(4, v);
      check("R8 no strobe on read", {31'b0, trig_o}, 0);
   endtask

   task automatic t_irq;
      logic [DW-1:0] v;
      dev_event = 1; @(negedge clk); dev_event = 0;
      bus_rd(3, v);
      check("R9 event sets pending", v, 32'h1);
      check("R10 masked irq low", {31'b0, irq_o}, 0);
      bus_wr(3, 32'h3);
      check("R10 irq with enable", {31'b0, irq_o}, 1);
      bus_wr(3, 32'h2);
      bus_rd(3, v);
      check("R9 bus clears pending", v, 32'h2);
      check("R10 irq drops on clear", {31'b0, irq_o}, 0);
      dev_event = 1; @(negedge clk); dev_event = 0;
      check("R10 irq on event", {31'b0, irq_o}, 1);
      dev_event = 1;
      bus_wr(3, 32'h2);
      dev_event = 0;
      bus_rd(3, v);
      check("R11 event beats clear", v, 32'h3);
      check("R11 irq stays high", {31'b0, irq_o}, 1);
      bus_wr(3, 32'h1);
      check("R10 disable drops irq", {31'b0, irq_o}, 0);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      t_reset;
      t_ctrl;
      t_readmux;
      t_bank;
      t_oor;
      t_trig;
      t_irq;
      done = 1;
      summary;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary;
      end
   end
endmodule